// File: doc/BRIEF.md
# Two-wire register write slave

This block lets a host on a two-wire serial bus write configuration registers inside the chip. It runs on the fast system clock and passes the bus clock and data lines through synchronizers. It finds start and stop conditions on the synchronized lines and shifts in an eight-bit device byte. When that byte selects this block for a write, the block acknowledges it and then takes two more bytes. Each acknowledge pulls the data line low through an open-drain enable.

The two payload bytes form one 16-bit control word. The upper seven bits are the register address and the lower nine bits are the register value. Once the last acknowledge is complete, the block issues a single-cycle write strobe carrying the address and the value. A register file elsewhere consumes that strobe. The block never answers a read, and it drops back to idle whenever a start or stop arrives in the wrong place.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset the open-drain enable `sda_oe_o` is 0 and the write strobe `wr_valid_o` is 0.
- R2: A falling data line while the clock line is high marks a start. After a start, bits are taken MSB first on rising bus clock edges: seven device-address bits, then the direction bit.
- R3: If the device byte equals 8'h34 (address 7'b0011010, direction bit 0), the block holds the data line low for the whole high phase of the ninth clock pulse.
- R4: If the device byte is anything else, including address 7'b0011010 with direction bit 1, the block does not acknowledge. It stays idle, acknowledges none of the bytes that follow, and issues no strobe.
- R5: Once the device byte has been acknowledged, the block acknowledges each of the next two bytes on their ninth clock pulse.
- R6: When the acknowledge of the second byte completes, `wr_valid_o` is 1 for exactly one system cycle. At that time `wr_addr_o` = byte1[7:1] and `wr_data_o` = {byte1[0], byte2[7:0]}.
- R7: A rising data line while the clock line is high marks a stop. A stop, or a start seen at any point of a transfer other than idle, returns the block to idle, releases the data line and gives no strobe. The start that aborted the transfer does not begin a new one.
- R8: `sda_oe_o` is 0 while data bits are being received. It rises only after a falling bus clock edge and falls after the falling edge that ends the acknowledge pulse.
- R9: After a complete transfer the block is idle, and the next start begins a fresh transfer that behaves identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| wr_valid_o | output | 1 | Single-cycle register write strobe |
| wr_addr_o | output | 7 | Register address, valid with the strobe |
| wr_data_o | output | 9 | Register value, valid with the strobe |

## Verification
Most internal faults in this block appear on the next acknowledge slot. A wrong bit count or a bad state transition shows up within one byte time as a missing, extra or misplaced low on the data line during the ninth clock pulse. A broken field split or shift order appears only at the end of the transfer, as a wrong address or value on the strobe. A missed abort can stay hidden until a later byte is acknowledged when it should not be, or until a strobe appears after a stop.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_B1,
    ST_B1_ACK,
    ST_B2,
    ST_B2_ACK
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;  // idle bus is high
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edge with clock held high on both samples
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/tw_rx_fsm.sv
module tw_rx_fsm
  import tw_reg_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter int         DATA_W   = 9,
  parameter logic [6:0] DEV_ADDR = 7'b0011010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output tw_state_e         state_o
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int HI_W   = BYTE_W - ADDR_W;  // data bits carried in byte 1
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] DEV_WR = {DEV_ADDR, 1'b0};

  tw_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] hi_byte;
  logic              ack_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      hi_byte    <= '0;
      ack_hi     <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_i) begin
        // start begins a transfer only from idle; elsewhere it aborts
        st       <= (st == ST_IDLE) ? ST_DEV : ST_IDLE;
        cnt      <= '0;
        ack_hi   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        ack_hi   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_B1, ST_B2: begin
            if (scl_rise_i && cnt != CNT_FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == CNT_FULL) begin
              cnt    <= '0;
              ack_hi <= 1'b0;
              case (st)
                ST_DEV: begin
                  if (shreg == DEV_WR) begin
                    sda_oe_o <= 1'b1;
                    st       <= ST_DEV_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                ST_B1: begin
                  hi_byte  <= shreg;
                  sda_oe_o <= 1'b1;
                  st       <= ST_B1_ACK;
                end
                default: begin
                  sda_oe_o <= 1'b1;
                  st       <= ST_B2_ACK;
                end
              endcase
            end
          end
          ST_DEV_ACK, ST_B1_ACK, ST_B2_ACK: begin
            if (scl_rise_i) begin
              ack_hi <= 1'b1;
            end else if (scl_fall_i && ack_hi) begin
              ack_hi   <= 1'b0;
              sda_oe_o <= 1'b0;
              case (st)
                ST_DEV_ACK: st <= ST_B1;
                ST_B1_ACK:  st <= ST_B2;
                default: begin
                  st         <= ST_IDLE;
                  wr_valid_o <= 1'b1;
                  wr_addr_o  <= hi_byte[BYTE_W-1 -: ADDR_W];
                  wr_data_o  <= {hi_byte[HI_W-1:0], shreg};
                end
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = st;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_reg_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter int         DATA_W      = 9,
  parameter logic [6:0] DEV_ADDR    = 7'b0011010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [1:0] line_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  tw_state_e  st;

  tw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  tw_cond_detect u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_rx_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (line_s[0]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .state_o    (st)
  );
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk
  import tw_reg_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      sda_oe_o,
  input logic      wr_valid_o,
  input tw_state_e st,
  input logic      scl_fall,
  input logic      stop_det
);
  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  assert_strobe_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($past(st) == ST_B2_ACK && st == ST_IDLE));

  assert_stop_to_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && st != ST_IDLE) |=> (st == ST_IDLE && !sda_oe_o));

  assert_oe_rise_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  assert_oe_only_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (st == ST_DEV_ACK || st == ST_B1_ACK || st == ST_B2_ACK));
endmodule

bind tw_reg_slave tw_reg_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .wr_valid_o (wr_valid_o),
  .st         (st),
  .scl_fall   (scl_fall),
  .stop_det   (stop_det)
);

// File: tb/tw_reg_slave_test.sv
module tw_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8 * CLK_PERIOD;  // quarter bus-bit time
  localparam int NV = 6;
  // {device byte, byte1, byte2, expect device ack}
  localparam logic [24:0] VEC [NV] = '{
    {8'h34, 8'h0F, 8'hA5, 1'b1},
    {8'h34, 8'hFE, 8'h00, 1'b1},
    {8'h34, 8'h01, 8'hFF, 1'b1},
    {8'h35, 8'h0F, 8'hA5, 1'b0},
    {8'h36, 8'h0F, 8'hA5, 1'b0},
    {8'hB4, 8'h22, 8'h33, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe_o, wr_valid_o;
  logic [6:0] wr_addr_o;
  logic [8:0] wr_data_o;
  wire sda_line = sda_m & ~sda_oe_o;

  int total = 0, bad = 0;
  int strobes = 0, strobe_cycles = 0, oe_in_data = 0;
  logic [6:0] last_addr;
  logic [8:0] last_data;
  logic prev_valid = 1'b0;

  tw_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (wr_valid_o) begin
      strobe_cycles++;
      if (!prev_valid) begin
        strobes++;
        last_addr = wr_addr_o;
        last_data = wr_data_o;
      end
    end
    prev_valid = wr_valid_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #(Q); scl = 1'b1; #(Q);
    sda_m = 1'b0; #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(Q); scl = 1'b1; #(Q);
    sda_m = 1'b1; #(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; #(Q); scl = 1'b1; #(Q);
      if (sda_oe_o) oe_in_data++;
      #(Q); scl = 1'b0; #(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ackd, output bit oe_after);
    send_bits(b, 8);
    sda_m = 1'b1; #(Q); scl = 1'b1; #(Q);
    ackd = ~sda_line; #(Q);
    ackd = ackd & ~sda_line;
    scl = 1'b0; #(Q);
    oe_after = sda_oe_o;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a0, a1, a2, r0, r1, r2;
    int s0;
    #(3*CLK_PERIOD + 2);
    chk(sda_oe_o == 1'b0, "R1 oe", int'(sda_oe_o), 0);
    chk(wr_valid_o == 1'b0, "R1 strobe", int'(wr_valid_o), 0);
    rst_ni = 1'b1;
    #(4*CLK_PERIOD);
    chk(sda_oe_o == 1'b0, "R1 oe after release", int'(sda_oe_o), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] dv, b1, b2;
      bit expa;
      dv = VEC[v][24:17]; b1 = VEC[v][16:9]; b2 = VEC[v][8:1]; expa = VEC[v][0];
      s0 = strobes;
      bus_start();
      send_byte(dv, a0, r0);
      chk(a0 == expa, expa ? "R3 device ack" : "R4 no device ack", int'(a0), int'(expa));
      chk(r0 == 1'b0, "R8 release after device ack", int'(r0), 0);
      send_byte(b1, a1, r1);
      send_byte(b2, a2, r2);
      chk(a1 == expa && a2 == expa, expa ? "R5 data acks" : "R4 no data acks",
          int'({a1, a2}), expa ? 3 : 0);
      chk(r1 == 1'b0 && r2 == 1'b0, "R8 release after data ack", int'({r1, r2}), 0);
      bus_stop();
      chk(strobes - s0 == (expa ? 1 : 0), expa ? "R6 strobe count" : "R4 no strobe",
          strobes - s0, expa ? 1 : 0);
      if (expa) begin
        chk(last_addr == b1[7:1], "R6 address", int'(last_addr), int'(b1[7:1]));
        chk(last_data == {b1[0], b2}, "R6 data", int'(last_data), int'({b1[0], b2}));
        chk(v == 0 || strobes > 1, "R9 back-to-back transfer", strobes, v + 1);
      end
    end
    chk(strobe_cycles == strobes, "R6 one-cycle strobe", strobe_cycles, strobes);
    chk(oe_in_data == 0, "R8 no drive during data bits", oe_in_data, 0);
    chk(strobes == 3, "R2 MSB-first transfers", strobes, 3);

    // stop after first data byte aborts
    s0 = strobes;
    bus_start();
    send_byte(8'h34, a0, r0);
    send_byte(8'h44, a1, r1);
    bus_stop();
    #(4*Q);
    chk(strobes == s0, "R7 stop abort no strobe", strobes - s0, 0);
    chk(sda_oe_o == 1'b0, "R7 stop releases line", int'(sda_oe_o), 0);

    // start in middle of second byte aborts; the start opens nothing
    s0 = strobes;
    bus_start();
    send_byte(8'h34, a0, r0);
    send_byte(8'h44, a1, r1);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(8'h34, a0, r0);
    chk(a0 == 1'b0, "R7 start abort stays idle", int'(a0), 0);
    send_byte(8'h55, a1, r1);
    chk(a1 == 1'b0, "R7 no ack after abort", int'(a1), 0);
    bus_stop();
    chk(strobes == s0, "R7 start abort no strobe", strobes - s0, 0);

    // fresh transfer after aborts
    bus_start();
    send_byte(8'h34, a0, r0);
    send_byte(8'h81, a1, r1);
    send_byte(8'h5A, a2, r2);
    bus_stop();
    chk(a0 && a1 && a2, "R9 acks after abort", int'({a0, a1, a2}), 7);
    chk(strobes == s0 + 1 && last_addr == 7'h40 && last_data == 9'h15A,
        "R9 strobe after abort", int'({last_addr, last_data}), int'({7'h40, 9'h15A}));
    chk(strobe_cycles == strobes, "R6 one-cycle strobe final", strobe_cycles, strobes);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule